// File: doc/BRIEF.md
# Spare-Element Remapping Chain

This block turns a long one-dimensional row of physical processing elements, some of which may be defective, into a shorter working chain of logical elements. A per-element enable mask is captured once, typically while the surrounding array is held in reset. From that mask the block gives every enabled element a logical position, counting upward from the lowest physical position. Enabled elements beyond the required logical count are left idle as spares. The block reports when too few elements are enabled to fill the chain.

For each logical element the block also keeps the physical position of its left and right logical neighbours. Disabled elements and spares are skipped, so they never take part in a transfer. The block holds one data word per physical element and moves words between logical neighbours over a narrow serial link of a few bits. One neighbour hop therefore takes several clocks. A run of hops shifts every word the requested number of logical positions in one direction, as is needed to gather the columns of a convolution window. The elements at either end of the chain receive zeros.

Top module: `spare_remap_chain`

## Requirements
- R1: After reset, no element is active, `short_flag` is 1, `busy` is 0 and every word of `word_out` is zero.
- R2: On a `cfg_load` accepted while idle, each enabled element whose count of enabled elements at lower physical positions is below NLOG becomes active, and that count is its logical index. Every other element reads active 0 and index 0. The index of element p sits at `log_idx[p*IDX_W +: IDX_W]`.
- R3: `short_flag` is 1 exactly when the last accepted mask enables fewer than NLOG elements.
- R4: A `cfg_load` pulsed while `busy` is 1 is ignored, and the mapping is left unchanged.
- R5: A `word_load` while idle captures `word_in[p*WORD_W +: WORD_W]` into the word of element p, for every p. A `word_load` while `busy` is 1 is ignored.
- R6: A transfer started with hop count H > 0 in direction 0 leaves each active element of logical index l holding the word that logical index l-H held before, or zero if l < H. In direction 1 the source is l+H, or zero when l+H does not exist among the active elements.
- R7: An `xfer_start` accepted while idle with H > 0 raises `busy` from the next clock for exactly H*(WORD_W/LINK_W) cycles. With H = 0 `busy` stays low and no word changes. If `word_load` is high in the same cycle, the load wins and the start is ignored.
- R8: Words of inactive elements (disabled or spare) are not changed by any transfer.
- R9: An `xfer_start` while `busy` is 1 is ignored, and the running transfer keeps its length.
- R10: In each busy cycle an active element shifts its word left by LINK_W bits. It takes the top LINK_W bits of its source neighbour's word (left neighbour in direction 0, right in direction 1) into its low bits. A chain end takes zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Capture `cfg_mask` and rebuild the mapping |
| cfg_mask | input | NPHYS | Per-physical-element enable, bit p = element p |
| word_load | input | 1 | Parallel load of all element words |
| word_in | input | NPHYS*WORD_W | Words to load, element p at bits p*WORD_W |
| xfer_start | input | 1 | Start a neighbour transfer run |
| xfer_dir | input | 1 | 0: words move toward higher logical index; 1: toward lower |
| xfer_hops | input | HOP_W | Number of neighbour hops H |
| busy | output | 1 | Transfer in progress |
| word_out | output | NPHYS*WORD_W | Current element words, element p at bits p*WORD_W |
| log_idx | output | NPHYS*IDX_W | Logical index per physical element |
| active | output | NPHYS | Element takes part in the logical chain |
| short_flag | output | 1 | Fewer than NLOG elements enabled |

## Verification
A wrong prefix count or neighbour pointer shows on `log_idx` and `active` on the first idle cycle after the mask is captured. It also shows in `word_out` after the first beat of any transfer: a wrong source puts foreign bits into the low LINK_W bits of an element one clock after the start edge. A bad beat or hop counter shows as a `busy` window of the wrong length and as words that have moved too far or not far enough. Spares that are wrongly driven show as changed words on elements that should hold still. The sweep covers every single-defect position and many multi-defect masks, in both directions and with several hop counts.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [0:0] {
    XF_IDLE = 1'b0,
    XF_RUN  = 1'b1
  } xf_state_e;

  // width that can hold values 0..n-1, never below one bit
  function automatic int bits_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/remap_calc.sv
module remap_calc #(
  parameter int NPHYS = 80,
  parameter int NLOG  = 64,
  parameter int IDX_W = 6,
  parameter int PTR_W = 7,
  parameter int CNT_W = 7
) (
  input  logic [NPHYS-1:0]            mask,
  output logic [NPHYS-1:0]            act,
  output logic [NPHYS-1:0][IDX_W-1:0] idx,
  output logic [NPHYS-1:0][PTR_W-1:0] lptr,
  output logic [NPHYS-1:0]            lvld,
  output logic [NPHYS-1:0][PTR_W-1:0] rptr,
  output logic [NPHYS-1:0]            rvld,
  output logic                        short_o
);

  localparam logic [CNT_W-1:0] NLOG_C = CNT_W'(NLOG);

  logic [CNT_W-1:0] run_cnt;
  logic [PTR_W-1:0] last_lo;
  logic             seen_lo;
  logic [PTR_W-1:0] last_hi;
  logic             seen_hi;

  // prefix count of enabled elements gives the logical position
  always_comb begin
    run_cnt = '0;
    for (int p = 0; p < NPHYS; p++) begin
      act[p] = 1'b0;
      idx[p] = '0;
      if (mask[p]) begin
        if (run_cnt < NLOG_C) begin
          act[p] = 1'b1;
          idx[p] = run_cnt[IDX_W-1:0];
        end
        run_cnt = run_cnt + CNT_W'(1);
      end
    end
    short_o = (run_cnt < NLOG_C);
  end

  // nearest active element below each position
  always_comb begin
    last_lo = '0;
    seen_lo = 1'b0;
    for (int p = 0; p < NPHYS; p++) begin
      lptr[p] = last_lo;
      lvld[p] = seen_lo;
      if (act[p]) begin
        last_lo = PTR_W'(p);
        seen_lo = 1'b1;
      end
    end
  end

  // nearest active element above each position
  always_comb begin
    last_hi = '0;
    seen_hi = 1'b0;
    for (int p = NPHYS - 1; p >= 0; p--) begin
      rptr[p] = last_hi;
      rvld[p] = seen_hi;
      if (act[p]) begin
        last_hi = PTR_W'(p);
        seen_hi = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import remap_pkg::*;
#(
  parameter int BEATS = 8,
  parameter int HOP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [HOP_W-1:0] hops,
  input  logic             load_word,
  output logic             busy,
  output logic             beat_en,
  output logic             dir_q
);

  localparam int BEAT_W = bits_for(BEATS);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

  xf_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [HOP_W-1:0]  hop_q, hop_d;
  logic [HOP_W-1:0]  hops_q, hops_d;
  logic              dir_d;
  logic              ctl_en;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    hop_d   = hop_q;
    hops_d  = hops_q;
    dir_d   = dir_q;
    case (state_q)
      XF_IDLE: begin
        if (start && !load_word && (hops != '0)) begin
          state_d = XF_RUN;
          beat_d  = '0;
          hop_d   = '0;
          hops_d  = hops;
          dir_d   = dir;
        end
      end
      XF_RUN: begin
        if (beat_q == BEAT_LAST) begin
          beat_d = '0;
          if (hop_q == (hops_q - HOP_W'(1))) begin
            state_d = XF_IDLE;
          end else begin
            hop_d = hop_q + HOP_W'(1);
          end
        end else begin
          beat_d = beat_q + BEAT_W'(1);
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  assign ctl_en = start || (state_q == XF_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      beat_q  <= '0;
      hop_q   <= '0;
      hops_q  <= '0;
      dir_q   <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      beat_q  <= beat_d;
      hop_q   <= hop_d;
      hops_q  <= hops_d;
      dir_q   <= dir_d;
    end
  end

  assign busy    = (state_q == XF_RUN);
  assign beat_en = (state_q == XF_RUN);

  // R7: the hop counter never passes the requested count
  assert_hop_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_RUN) |-> (hop_q < hops_q));

  // R7: a run only ends on the last beat of a hop
  assert_end_on_last_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(beat_q) == BEAT_LAST));

  // R9: a start during a run does not touch the stored hop count
  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(hops_q));

endmodule

// File: rtl/chain_shift.sv
module chain_shift #(
  parameter int NPHYS  = 80,
  parameter int WORD_W = 16,
  parameter int LINK_W = 2,
  parameter int PTR_W  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [NPHYS-1:0][WORD_W-1:0] word_in,
  input  logic                         beat_en,
  input  logic                         dir,
  input  logic [NPHYS-1:0]             act,
  input  logic [NPHYS-1:0][PTR_W-1:0]  lptr,
  input  logic [NPHYS-1:0]             lvld,
  input  logic [NPHYS-1:0][PTR_W-1:0]  rptr,
  input  logic [NPHYS-1:0]             rvld,
  output logic [NPHYS-1:0][WORD_W-1:0] word_q
);

  // WORD_W must be a multiple of LINK_W and larger than it
  for (genvar p = 0; p < NPHYS; p++) begin : g_elem
    logic [LINK_W-1:0] src;
    logic [WORD_W-1:0] word_d;
    logic              elem_en;

    // serial bits arrive from the logical neighbour on the source side
    always_comb begin
      if (!dir) begin
        src = lvld[p] ? word_q[lptr[p]][WORD_W-1 -: LINK_W] : '0;
      end else begin
        src = rvld[p] ? word_q[rptr[p]][WORD_W-1 -: LINK_W] : '0;
      end
    end

    always_comb begin
      if (load_en) begin
        word_d = word_in[p];
      end else begin
        word_d = {word_q[p][WORD_W-LINK_W-1:0], src};
      end
    end

    assign elem_en = load_en || (beat_en && act[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[p] <= '0;
      end else if (elem_en) begin
        word_q[p] <= word_d;
      end
    end

    // R8: spares and disabled elements keep their word during a run
    assert_spare_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && !act[p] && !load_en) |=> $stable(word_q[p]));
  end

endmodule

// File: rtl/spare_remap_chain.sv
module spare_remap_chain #(
  parameter int NPHYS  = 80,
  parameter int NLOG   = 64,
  parameter int WORD_W = 16,
  parameter int LINK_W = 2,
  parameter int HOP_W  = 4,
  localparam int IDX_W = remap_pkg::bits_for(NLOG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [NPHYS-1:0]        cfg_mask,
  input  logic                    word_load,
  input  logic [NPHYS*WORD_W-1:0] word_in,
  input  logic                    xfer_start,
  input  logic                    xfer_dir,
  input  logic [HOP_W-1:0]        xfer_hops,
  output logic                    busy,
  output logic [NPHYS*WORD_W-1:0] word_out,
  output logic [NPHYS*IDX_W-1:0]  log_idx,
  output logic [NPHYS-1:0]        active,
  output logic                    short_flag
);

  localparam int PTR_W = remap_pkg::bits_for(NPHYS);
  localparam int CNT_W = remap_pkg::bits_for(NPHYS + 1);
  localparam int BEATS = WORD_W / LINK_W;

  // reset: asserted at once, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // mapping computed from the incoming mask
  logic [NPHYS-1:0]            act_d;
  logic [NPHYS-1:0][IDX_W-1:0] idx_d;
  logic [NPHYS-1:0][PTR_W-1:0] lptr_d, rptr_d;
  logic [NPHYS-1:0]            lvld_d, rvld_d;
  logic                        short_d;

  remap_calc #(
    .NPHYS(NPHYS), .NLOG(NLOG), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_calc (
    .mask   (cfg_mask),
    .act    (act_d),
    .idx    (idx_d),
    .lptr   (lptr_d),
    .lvld   (lvld_d),
    .rptr   (rptr_d),
    .rvld   (rvld_d),
    .short_o(short_d)
  );

  // static mapping registers
  logic [NPHYS-1:0]            act_q;
  logic [NPHYS-1:0][IDX_W-1:0] idx_q;
  logic [NPHYS-1:0][PTR_W-1:0] lptr_q, rptr_q;
  logic [NPHYS-1:0]            lvld_q, rvld_q;
  logic                        short_q;
  logic                        map_en;
  logic                        busy_w;

  assign map_en = cfg_load && !busy_w;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q   <= '0;
      idx_q   <= '0;
      lptr_q  <= '0;
      rptr_q  <= '0;
      lvld_q  <= '0;
      rvld_q  <= '0;
      short_q <= 1'b1;
    end else if (map_en) begin
      act_q   <= act_d;
      idx_q   <= idx_d;
      lptr_q  <= lptr_d;
      rptr_q  <= rptr_d;
      lvld_q  <= lvld_d;
      rvld_q  <= rvld_d;
      short_q <= short_d;
    end
  end

  // transfer sequencing
  logic beat_en, dir_q;

  xfer_ctrl #(.BEATS(BEATS), .HOP_W(HOP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (xfer_start),
    .dir      (xfer_dir),
    .hops     (xfer_hops),
    .load_word(word_load),
    .busy     (busy_w),
    .beat_en  (beat_en),
    .dir_q    (dir_q)
  );

  // word storage and serial neighbour path
  logic [NPHYS-1:0][WORD_W-1:0] word_in_a, word_q;
  logic                         load_en;

  assign load_en = word_load && !busy_w;

  chain_shift #(
    .NPHYS(NPHYS), .WORD_W(WORD_W), .LINK_W(LINK_W), .PTR_W(PTR_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_en(load_en),
    .word_in(word_in_a),
    .beat_en(beat_en),
    .dir    (dir_q),
    .act    (act_q),
    .lptr   (lptr_q),
    .lvld   (lvld_q),
    .rptr   (rptr_q),
    .rvld   (rvld_q),
    .word_q (word_q)
  );

  for (genvar p = 0; p < NPHYS; p++) begin : g_flat
    assign word_in_a[p]                   = word_in[p*WORD_W +: WORD_W];
    assign word_out[p*WORD_W +: WORD_W]   = word_q[p];
    assign log_idx[p*IDX_W +: IDX_W]      = idx_q[p];

    // R2: an active element sits one place after its left neighbour
    assert_chain_order_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (act_q[p] && lvld_q[p]) |-> ((idx_q[lptr_q[p]] + IDX_W'(1)) == idx_q[p]));

    // R2: an active element with no left neighbour is the chain head
    assert_chain_head_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (act_q[p] && !lvld_q[p]) |-> (idx_q[p] == '0));
  end

  assign busy       = busy_w;
  assign active     = act_q;
  assign short_flag = short_q;

  // R3: the short flag agrees with the number of active elements
  assert_full_chain_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !short_q |-> ($countones(act_q) == NLOG));

  assert_short_chain_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    short_q |-> ($countones(act_q) < NLOG));

  // R4: the mapping is frozen while a transfer runs
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_w && cfg_load) |=> $stable(act_q));

endmodule

// File: tb/spare_remap_chain_bench.sv
module spare_remap_chain_bench;

  localparam int NP = 20;
  localparam int NL = 16;
  localparam int WW = 8;
  localparam int LW = 2;
  localparam int HW = 3;
  localparam int IW = 4;
  localparam int BEATS = WW / LW;

  logic              clk;
  logic              rst_n;
  logic              cfg_load;
  logic [NP-1:0]     cfg_mask;
  logic              word_load;
  logic [NP*WW-1:0]  word_in;
  logic              xfer_start;
  logic              xfer_dir;
  logic [HW-1:0]     xfer_hops;
  logic              busy;
  logic [NP*WW-1:0]  word_out;
  logic [NP*IW-1:0]  log_idx;
  logic [NP-1:0]     active;
  logic              short_flag;

  spare_remap_chain #(
    .NPHYS(NP), .NLOG(NL), .WORD_W(WW), .LINK_W(LW), .HOP_W(HW)
  ) u_spare_remap_chain (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mask(cfg_mask),
    .word_load(word_load), .word_in(word_in), .xfer_start(xfer_start),
    .xfer_dir(xfer_dir), .xfer_hops(xfer_hops), .busy(busy),
    .word_out(word_out), .log_idx(log_idx), .active(active),
    .short_flag(short_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int wd    = 0;

  // bench model
  bit           exp_act [NP];
  int           exp_idx [NP];
  int           phys_of [NL];
  int           n_act;
  bit           exp_short;
  logic [WW-1:0] cur [NP];
  logic [WW-1:0] nxt [NP];

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog R7 busy actual=%0d expected=0", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [WW-1:0] wout(input int p);
    return word_out[p*WW +: WW];
  endfunction

  task automatic build_map(input logic [NP-1:0] m);
    int cnt = 0;
    for (int p = 0; p < NP; p++) begin
      exp_act[p] = 1'b0;
      exp_idx[p] = 0;
      if (m[p]) begin
        if (cnt < NL) begin
          exp_act[p] = 1'b1;
          exp_idx[p] = cnt;
          phys_of[cnt] = p;
        end
        cnt++;
      end
    end
    n_act = (cnt < NL) ? cnt : NL;
    exp_short = (cnt < NL);
  endtask

  task automatic check_map(input string tag);
    for (int p = 0; p < NP; p++) begin
      chk(active[p] == exp_act[p], {"R2 active ", tag}, active[p], exp_act[p]);
      chk(int'(log_idx[p*IW +: IW]) == exp_idx[p], {"R2 index ", tag},
          log_idx[p*IW +: IW], exp_idx[p]);
    end
    chk(short_flag == exp_short, {"R3 short ", tag}, short_flag, exp_short);
  endtask

  task automatic do_cfg(input logic [NP-1:0] m);
    @(negedge clk);
    cfg_mask = m;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    build_map(m);
    check_map("cfg");
  endtask

  task automatic load_words(input int seed);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      cur[p] = WW'(p * 37 + seed * 11 + 3);
      word_in[p*WW +: WW] = cur[p];
    end
    word_load = 1'b1;
    @(negedge clk);
    word_load = 1'b0;
    for (int p = 0; p < NP; p++)
      chk(wout(p) == cur[p], "R5 word load", wout(p), cur[p]);
  endtask

  // disturb: pokes cfg_load, word_load and xfer_start mid-run
  // peek: checks the state before and after the first beat
  task automatic run_xfer(input bit dir, input int h, input bit disturb, input bit peek);
    int cyc = 0;
    for (int p = 0; p < NP; p++) nxt[p] = cur[p];
    for (int l = 0; l < n_act; l++) begin
      int s = dir ? l + h : l - h;
      nxt[phys_of[l]] = (s >= 0 && s < n_act) ? cur[phys_of[s]] : '0;
    end
    @(negedge clk);
    xfer_dir   = dir;
    xfer_hops  = HW'(h);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    while (busy) begin
      cyc++;
      if (peek && cyc == 1) begin
        for (int p = 0; p < NP; p++)
          chk(wout(p) == cur[p], "R10 before first beat", wout(p), cur[p]);
      end
      if (peek && cyc == 2) begin
        for (int p = 0; p < NP; p++) begin
          logic [WW-1:0] e = cur[p];
          if (exp_act[p]) begin
            int s = dir ? exp_idx[p] + 1 : exp_idx[p] - 1;
            logic [LW-1:0] b = (s >= 0 && s < n_act) ? cur[phys_of[s]][WW-1 -: LW] : '0;
            e = {cur[p][WW-LW-1:0], b};
          end
          chk(wout(p) == e, "R10 one beat", wout(p), e);
        end
      end
      if (disturb && cyc == 2) begin
        cfg_mask   = ~cfg_mask;
        cfg_load   = 1'b1;
        word_load  = 1'b1;
        word_in    = ~word_in;
        xfer_hops  = 3'd7;
        xfer_start = 1'b1;
      end
      if (disturb && cyc == 3) begin
        cfg_load   = 1'b0;
        word_load  = 1'b0;
        xfer_start = 1'b0;
      end
      @(negedge clk);
    end
    cfg_load = 1'b0;
    word_load = 1'b0;
    xfer_start = 1'b0;
    chk(cyc == h * BEATS, disturb ? "R9 busy length" : "R7 busy length", cyc, h * BEATS);
    for (int p = 0; p < NP; p++) begin
      if (exp_act[p]) chk(wout(p) == nxt[p], "R6 moved word", wout(p), nxt[p]);
      else            chk(wout(p) == nxt[p], "R8 spare word held", wout(p), nxt[p]);
      cur[p] = nxt[p];
    end
    if (disturb) begin
      for (int p = 0; p < NP; p++)
        chk(active[p] == exp_act[p], "R4 mapping frozen", active[p], exp_act[p]);
      chk(short_flag == exp_short, "R4 short frozen", short_flag, exp_short);
    end
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int rnd(input int m);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'(lfsr[15:0]) % m;
  endfunction

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_mask = '0; word_load = 1'b0;
    word_in = '0; xfer_start = 1'b0; xfer_dir = 1'b0; xfer_hops = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(active == '0, "R1 active", active, 0);
    chk(short_flag == 1'b1, "R1 short", short_flag, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(word_out == '0, "R1 words", word_out != '0, 0);

    // fixed corner masks
    do_cfg(20'hFFFFF); load_words(1);
    run_xfer(1'b0, 1, 1'b0, 1'b1);
    run_xfer(1'b1, 2, 1'b0, 1'b1);
    run_xfer(1'b0, 0, 1'b0, 1'b0);
    do_cfg(20'h0FFFF); load_words(2); run_xfer(1'b1, 3, 1'b0, 1'b0);
    do_cfg(20'hFFFF0); load_words(3); run_xfer(1'b0, 2, 1'b1, 1'b0);
    do_cfg(20'h07FFF); load_words(4); run_xfer(1'b1, 1, 1'b0, 1'b1);
    do_cfg(20'hAAAAA); load_words(5); run_xfer(1'b0, 3, 1'b0, 1'b0);
    do_cfg(20'h00000); run_xfer(1'b0, 1, 1'b0, 1'b0);

    // R7: load and start together, load wins
    do_cfg(20'hFFFFF); load_words(6);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      cur[p] = WW'(p * 5 + 1);
      word_in[p*WW +: WW] = cur[p];
    end
    word_load = 1'b1; xfer_start = 1'b1; xfer_hops = 3'd2;
    @(negedge clk);
    word_load = 1'b0; xfer_start = 1'b0;
    chk(busy == 1'b0, "R7 load beats start", busy, 0);
    for (int p = 0; p < NP; p++)
      chk(wout(p) == cur[p], "R7 load beats start word", wout(p), cur[p]);

    // every single-defect position
    for (int k = 0; k < NP; k++) begin
      do_cfg(~(20'(1) << k));
      load_words(k + 10);
      run_xfer(1'b0, 1, 1'b0, 1'b1);
      run_xfer(1'b1, 2, (k % 3) == 0, 1'b0);
    end

    // multi-defect masks
    for (int t = 0; t < 40; t++) begin
      logic [NP-1:0] m = '1;
      int nd = 1 + rnd(6);
      for (int d = 0; d < nd; d++) m[rnd(NP)] = 1'b0;
      do_cfg(m);
      load_words(t + 40);
      run_xfer(t[0], 1 + rnd(4), (t % 4) == 1, (t % 5) == 0);
      run_xfer(~t[0], rnd(4), 1'b0, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule